// File: doc/BRIEF.md
# Return Target Prediction Stack

This block predicts where subroutine returns will land. Each cycle the front end may report one control transfer, tagged with a class code and its fall-through address. Calls record their fall-through address on a small hardware stack. Returns take the top entry off that stack and offer it as the predicted target. The stack only follows the class codes. Ordinary data accesses to the memory stack never reach it, so a call that software undoes with a data pop leaves a stale entry behind. Every later return is then predicted from the wrong entry.

A return's real target resolves one cycle after the return is issued. The block compares it with the prediction it registered at issue time. It raises a mispredict pulse when the two differ and keeps saturating tallies of correct and incorrect predictions. The stack is a fixed-depth circular buffer. It never stalls: a push into a full stack overwrites the oldest entry.

Top module: `ret_target_stack`

## Requirements
- R1: A synchronous active-high reset empties the stack, clears both tallies to zero, and holds `predValid` and `mispredict` low.
- R2: A transfer with `xferValid` high and class 1 (call) pushes `fallThru`. A later class 2 (return) issued at clock edge E puts that address on `predTarget`, with `predValid` high, in the cycle after E.
- R3: Nested calls are predicted in last-in first-out order.
- R4: Class 0 (plain jump), and any cycle with `xferValid` low, leave the stack contents and the stack depth unchanged.
- R5: `actualTarget` is sampled in the cycle after the return is issued. In that same cycle `mispredict` is high exactly when the prediction is invalid or differs from `actualTarget`. The popped entry is consumed either way, so a stale entry keeps every later prediction off by one.
- R6: Class 3 (coroutine) predicts from the top entry and replaces that entry with its own `fallThru` in the same cycle. On an empty stack it gives an invalid prediction and pushes `fallThru`.
- R7: With 8 entries, a ninth push with no pops in between overwrites the oldest entry. The following returns predict the eight newest addresses, newest first, and the next return is invalid.
- R8: A return on an empty stack gives `predValid` low and a mispredict, and leaves the stack empty, so a following call/return pair still predicts correctly.
- R9: `hitCount` or `missCount` grows by one in the cycle after each checked return or coroutine. Correct predictions add to `hitCount`; invalid or wrong ones add to `missCount`. Each tally saturates at 65535.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| xferValid | input | 1 | A control transfer is reported this cycle |
| xferClass | input | 2 | 0 jump, 1 call, 2 return, 3 coroutine |
| fallThru | input | 16 | Fall-through address of the transfer |
| actualTarget | input | 16 | Resolved target of the return issued one cycle earlier |
| predTarget | output | 16 | Predicted return target |
| predValid | output | 1 | Prediction present and backed by a stack entry |
| mispredict | output | 1 | Checked prediction was invalid or wrong |
| hitCount | output | 16 | Saturating tally of correct predictions |
| missCount | output | 16 | Saturating tally of incorrect predictions |

## Verification
The assertions check these rules on every cycle:
- the depth never exceeds eight, and a jump leaves the pointer and depth untouched;
- a call grows a non-full stack by one;
- an entry written by a push holds its address;
- a mispredict only ever follows a checked transfer;
- the tallies saturate and never jump by more than one.

Only the bench scenarios can show that predictions come back in the right order across nesting, overflow, coroutine swaps and a stale entry left by an unmatched call. The bench compares every prediction against an independent stack model.

// File: rtl/rts_pkg.sv
package rts_pkg;

  typedef enum logic [1:0] {
    XFER_JUMP = 2'd0,
    XFER_CALL = 2'd1,
    XFER_RET  = 2'd2,
    XFER_CORO = 2'd3
  } xfer_class_e;

  typedef struct packed {
    logic push;
    logic swap;
    logic capture;
    logic hasEntry;
  } stack_strobe_t;

endpackage

// File: rtl/rts_datapath.sv
module rts_datapath
  import rts_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 8,
  localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  stack_strobe_t     strb,
  input  logic [PW-1:0]     wrIdx,
  input  logic [PW-1:0]     rdIdx,
  input  logic [ADDR_W-1:0] fallThru,
  input  logic [ADDR_W-1:0] actualTarget,
  output logic [ADDR_W-1:0] predTarget,
  output logic              predValid,
  output logic              mismatch
);

  logic [ADDR_W-1:0] entryMem [DEPTH];
  logic [ADDR_W-1:0] predQ;
  logic              predValidQ;

  // entry storage: one write port, the top entry is read before it is overwritten
  always_ff @(posedge clk) begin
    if (strb.push || strb.swap) begin
      entryMem[wrIdx] <= fallThru;
    end
  end

  // prediction is registered at issue time
  always_ff @(posedge clk) begin
    if (rst) begin
      predValidQ <= 1'b0;
      predQ      <= '0;
    end else begin
      predValidQ <= strb.capture && strb.hasEntry;
      if (strb.capture) begin
        predQ <= entryMem[rdIdx];
      end
    end
  end

  assign predTarget = predQ;
  assign predValid  = predValidQ;
  assign mismatch   = !predValidQ || (predQ != actualTarget);

  a_r2_push_stored: assert property (@(posedge clk) disable iff (rst)
    strb.push |=> entryMem[$past(wrIdx)] == $past(fallThru));

endmodule

// File: rtl/rts_ctrl.sv
module rts_ctrl
  import rts_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int CNT_W  = 16,
  localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             xferValid,
  input  logic [1:0]       xferClass,
  input  logic             mismatch,
  output stack_strobe_t    strb,
  output logic [PW-1:0]    wrIdx,
  output logic [PW-1:0]    rdIdx,
  output logic             mispredict,
  output logic [CNT_W-1:0] hitCount,
  output logic [CNT_W-1:0] missCount
);

  localparam logic [OCC_W-1:0] FULL    = OCC_W'(DEPTH);
  localparam logic [PW-1:0]    LASTIDX = PW'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  xfer_class_e      cls;
  logic             isCall, isRet, isCoro, isJump, isEmpty, doPop;
  logic [PW-1:0]    topPtr, ptrUp, ptrDn;
  logic [OCC_W-1:0] occupancy;
  logic             checkPending;

  assign cls    = xfer_class_e'(xferClass);
  assign isCall = xferValid && (cls == XFER_CALL);
  assign isRet  = xferValid && (cls == XFER_RET);
  assign isCoro = xferValid && (cls == XFER_CORO);
  assign isJump = xferValid && (cls == XFER_JUMP);

  assign isEmpty = (occupancy == '0);
  assign ptrUp   = (topPtr == LASTIDX) ? '0 : topPtr + 1'b1;
  assign ptrDn   = (topPtr == '0) ? LASTIDX : topPtr - 1'b1;

  always_comb begin
    strb.hasEntry = !isEmpty;
    strb.capture  = isRet || isCoro;
    strb.swap     = isCoro && !isEmpty;
    strb.push     = isCall || (isCoro && isEmpty);
    doPop         = isRet && !isEmpty;
  end

  assign wrIdx = strb.swap ? topPtr : ptrUp;
  assign rdIdx = topPtr;

  // pointer and occupancy; a push into a full stack wraps over the oldest entry
  always_ff @(posedge clk) begin
    if (rst) begin
      topPtr    <= '0;
      occupancy <= '0;
    end else if (strb.push) begin
      topPtr    <= ptrUp;
      occupancy <= (occupancy == FULL) ? occupancy : occupancy + 1'b1;
    end else if (doPop) begin
      topPtr    <= ptrDn;
      occupancy <= occupancy - 1'b1;
    end
  end

  // deferred check and saturating tallies
  always_ff @(posedge clk) begin
    if (rst) begin
      checkPending <= 1'b0;
      hitCount     <= '0;
      missCount    <= '0;
    end else begin
      checkPending <= strb.capture;
      if (checkPending) begin
        if (mismatch) begin
          if (missCount != CNT_MAX) missCount <= missCount + 1'b1;
        end else begin
          if (hitCount != CNT_MAX) hitCount <= hitCount + 1'b1;
        end
      end
    end
  end

  assign mispredict = checkPending && mismatch;

  a_r7_depth_bound: assert property (@(posedge clk) disable iff (rst)
    occupancy <= FULL);

  a_r4_jump_holds: assert property (@(posedge clk) disable iff (rst)
    isJump |=> $stable(topPtr) && $stable(occupancy));

  a_r2_call_grows: assert property (@(posedge clk) disable iff (rst)
    (isCall && occupancy != FULL) |=> occupancy == $past(occupancy) + 1'b1);

  a_r8_empty_return_stays: assert property (@(posedge clk) disable iff (rst)
    (isRet && isEmpty) |=> occupancy == '0);

  a_r5_misp_follows_check: assert property (@(posedge clk) disable iff (rst)
    mispredict |-> $past(strb.capture));

  a_r9_hit_saturates: assert property (@(posedge clk) disable iff (rst)
    hitCount == CNT_MAX |=> hitCount == CNT_MAX);

  a_r9_miss_saturates: assert property (@(posedge clk) disable iff (rst)
    missCount == CNT_MAX |=> missCount == CNT_MAX);

  a_r9_single_step: assert property (@(posedge clk) disable iff (rst)
    !checkPending |=> $stable(hitCount) && $stable(missCount));

endmodule

// File: rtl/ret_target_stack.sv
module ret_target_stack
  import rts_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 8,
  parameter int CNT_W  = 16,
  localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              xferValid,
  input  logic [1:0]        xferClass,
  input  logic [ADDR_W-1:0] fallThru,
  input  logic [ADDR_W-1:0] actualTarget,
  output logic [ADDR_W-1:0] predTarget,
  output logic              predValid,
  output logic              mispredict,
  output logic [CNT_W-1:0]  hitCount,
  output logic [CNT_W-1:0]  missCount
);

  stack_strobe_t strb;
  logic [PW-1:0] wrIdx, rdIdx;
  logic          mismatch;

  rts_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .xferValid(xferValid), .xferClass(xferClass),
    .mismatch(mismatch), .strb(strb), .wrIdx(wrIdx), .rdIdx(rdIdx),
    .mispredict(mispredict), .hitCount(hitCount), .missCount(missCount)
  );

  rts_datapath #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .wrIdx(wrIdx), .rdIdx(rdIdx),
    .fallThru(fallThru), .actualTarget(actualTarget),
    .predTarget(predTarget), .predValid(predValid), .mismatch(mismatch)
  );

endmodule

// File: tb/sim_ret_target_stack.sv
module sim_ret_target_stack;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        xferValid = 1'b0;
  logic [1:0]  xferClass = 2'd0;
  logic [15:0] fallThru = '0;
  logic [15:0] actualTarget = '0;
  logic [15:0] predTarget;
  logic        predValid, mispredict;
  logic [15:0] hitCount, missCount;

  ret_target_stack u0 (
    .clk(clk), .rst(rst), .xferValid(xferValid), .xferClass(xferClass),
    .fallThru(fallThru), .actualTarget(actualTarget), .predTarget(predTarget),
    .predValid(predValid), .mispredict(mispredict),
    .hitCount(hitCount), .missCount(missCount)
  );

  always #10 clk = ~clk;

  typedef struct {
    int          due;
    bit          expValid;
    logic [15:0] expTarget;
    logic [15:0] act;
    string       req;
  } item_t;

  item_t       expQ[$];
  logic [15:0] model[$];
  int          cycleCount = 0;
  int          nCompared = 0;
  int          nMismatched = 0;
  int          modelHit = 0;
  int          modelMiss = 0;
  logic [15:0] nextAct = '0;
  bit          done = 0;

  always @(posedge clk) cycleCount <= cycleCount + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    nCompared++;
    if (!ok) begin
      nMismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
      $finish;
    end
  endtask

  // driver: one transfer per cycle, expected results go to the scoreboard
  task automatic step(input bit v, input logic [1:0] cls, input logic [15:0] ft,
                      input logic [15:0] act, input string req);
    item_t it;
    @(negedge clk);
    xferValid    = v;
    xferClass    = cls;
    fallThru     = ft;
    actualTarget = nextAct;
    nextAct      = act;
    if (v && (cls == 2'd2 || cls == 2'd3)) begin
      it.due = cycleCount + 1;
      it.act = act;
      it.req = req;
      it.expValid  = (model.size() > 0);
      it.expTarget = it.expValid ? model[0] : 16'h0;
      if (cls == 2'd2) begin
        if (model.size() > 0) void'(model.pop_front());
      end else begin
        if (model.size() > 0) model[0] = ft;
        else model.push_front(ft);
      end
      if (it.expValid && it.expTarget == act) begin
        if (modelHit < 65535) modelHit++;
      end else begin
        if (modelMiss < 65535) modelMiss++;
      end
      expQ.push_back(it);
    end else if (v && cls == 2'd1) begin
      model.push_front(ft);
      if (model.size() > 8) void'(model.pop_back());
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 2'd0, 16'h0, 16'h0, "");
  endtask

  task automatic call(input logic [15:0] a);
    step(1'b1, 2'd1, a, 16'h0, "");
  endtask

  task automatic ret(input logic [15:0] act, input string req);
    step(1'b1, 2'd2, 16'h0, act, req);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    idle(2);
    @(negedge clk);
    rst = 1'b0;
    model.delete();
    nextAct  = '0;
    modelHit = 0;
    modelMiss = 0;
  endtask

  task automatic checkCounts(input string req);
    idle(2);
    #2;
    check(hitCount == modelHit[15:0], req, "hitCount", hitCount, modelHit);
    check(missCount == modelMiss[15:0], req, "missCount", missCount, modelMiss);
  endtask

  // monitor: compares each due prediction
  always @(negedge clk) begin
    #2;
    while (expQ.size() > 0 && expQ[0].due == cycleCount) begin
      item_t it;
      bit    expMis;
      it = expQ.pop_front();
      expMis = !it.expValid || (it.expTarget != it.act);
      check(predValid == it.expValid, it.req, "predValid", predValid, it.expValid);
      if (it.expValid)
        check(predTarget == it.expTarget, it.req, "predTarget", predTarget, it.expTarget);
      check(mispredict == expMis, it.req, "mispredict", mispredict, expMis);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    nMismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    idle(3);
    #2;
    // R1 reset state
    check(predValid == 1'b0, "R1", "predValid", predValid, 0);
    check(mispredict == 1'b0, "R1", "mispredict", mispredict, 0);
    check(hitCount == 0 && missCount == 0, "R1", "tallies", {hitCount, missCount}, 0);
    @(negedge clk);
    rst = 1'b0;

    // R2 single call/return
    call(16'h1000);
    ret(16'h1000, "R2");
    idle(1);

    // R3 nesting, R4 jumps and idle cycles in between
    call(16'h2000); call(16'h2100); call(16'h2200);
    step(1'b1, 2'd0, 16'hDEAD, 16'h0, "R4");
    idle(2);
    step(1'b1, 2'd0, 16'hBEEF, 16'h0, "R4");
    ret(16'h2200, "R3_R4"); ret(16'h2100, "R3"); ret(16'h2000, "R3");
    idle(1);
    checkCounts("R9");

    // R5 unmatched call leaves a stale top entry
    call(16'h3001); call(16'h3002); call(16'h3003);
    call(16'h30FF);
    ret(16'h3003, "R5"); ret(16'h3002, "R5"); ret(16'h3001, "R5");
    ret(16'h0042, "R5");
    idle(1);

    // R8 empty return, then normal pair
    ret(16'h4444, "R8");
    ret(16'h4445, "R8");
    call(16'h4500);
    ret(16'h4500, "R8");
    idle(1);

    // R6 coroutine swap and coroutine on empty
    call(16'h5000);
    step(1'b1, 2'd3, 16'h5100, 16'h5000, "R6");
    ret(16'h5100, "R6");
    step(1'b1, 2'd3, 16'h5200, 16'h0001, "R6");
    ret(16'h5200, "R6");
    idle(1);
    checkCounts("R9");

    // R7 overflow overwrites oldest
    for (int i = 1; i <= 9; i++) call(16'h6000 + 16'(i));
    for (int i = 9; i >= 1; i--) ret(16'h6000 + 16'(i), "R7");
    idle(1);
    checkCounts("R9");

    // R9 miss tally saturation
    for (int i = 0; i < 65540; i++) ret(16'h7777, "R9");
    idle(1);
    checkCounts("R9");
    check(missCount == 16'hFFFF, "R9", "missCount saturated", missCount, 16'hFFFF);

    // R1 reset mid-run clears tallies and stack
    call(16'h8000);
    idle(1);
    doReset();
    #2;
    check(hitCount == 0 && missCount == 0, "R1", "tallies after reset",
          {hitCount, missCount}, 0);
    ret(16'h8000, "R1");
    idle(2);
    finishRun();
  end

endmodule